// File: doc/BRIEF.md
# Multi-Mode Triplet Sample FIFO

This block buffers up to 32 acceleration samples, each a complete x/y/z triplet, between a sample producer and a reader. The producer presents one triplet with a push strobe. The reader sees the oldest unread triplet on the pop outputs at all times, and a pop strobe consumes it. A two-bit mode input chooses how the buffer behaves when it runs out of room.

The four modes are a single-slot latest-value holder, a buffer that stops collecting when it is full, a rolling buffer that keeps the newest samples, and a capture mode. In capture mode the buffer rolls until a trigger arrives. It then keeps only the newest n samples, where n is the level input, and fills the rest of the buffer with new samples until it is full. The level input also sets the watermark. Status outputs give the unread count, a watermark flag, a sticky overrun flag and a triggered bit.

Top module: `triplet_fifo`

## Requirements
- R1: Mode codes are 00 single-slot, 01 stop-when-full, 10 rolling, 11 capture. In any cycle where `mode_i` differs from the mode used in the previous cycle, the block empties the buffer and clears the overrun and triggered bits. Push, pop and trigger are ignored in that cycle.
- R2: Triplets are read in the order they were written. `count_o` reports 0 to 32 unread entries. A pop while empty has no effect.
- R3: In stop-when-full mode, a push into a full buffer with no pop discards the new triplet, leaves the contents unchanged and sets `ovr_o`.
- R4: In rolling mode, a push into a full buffer with no pop drops the oldest entry, stores the new one and sets `ovr_o`.
- R5: In single-slot mode at most one triplet is held. A push onto an unread triplet with no pop replaces it and sets `ovr_o`.
- R6: In capture mode, before a trigger, the buffer behaves as in rolling mode.
- R7: In capture mode, a `trig_i` cycle before a trigger has been taken sets `trg_o`. That cycle's push is applied first and its pop is ignored. Afterwards only the newest `level_i` entries stay; nothing is removed if the count is already at or below the level.
- R8: In capture mode, after a trigger, the buffer fills like stop-when-full mode. Further triggers are ignored, and `trg_o` stays set until a mode change.
- R9: `wm_o` is high whenever `count_o` is at least `level_i`.
- R10: `ovr_o` is sticky. A pop that takes effect clears it, except when the same cycle raises a new overrun; in that case set wins.
- R11: A push and a pop in the same cycle on a full buffer keep the count unchanged and raise no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Retention mode select |
| level_i | input | 5 | Watermark and capture retention level |
| push_i | input | 1 | Producer write strobe |
| push_x_i | input | 16 | Pushed x sample |
| push_y_i | input | 16 | Pushed y sample |
| push_z_i | input | 16 | Pushed z sample |
| pop_i | input | 1 | Reader consume strobe |
| pop_x_o | output | 16 | Oldest unread x sample |
| pop_y_o | output | 16 | Oldest unread y sample |
| pop_z_o | output | 16 | Oldest unread z sample |
| trig_i | input | 1 | Trigger event strobe |
| count_o | output | 6 | Unread entry count |
| wm_o | output | 1 | Watermark reached |
| ovr_o | output | 1 | Sticky overrun flag |
| trg_o | output | 1 | Trigger has been taken |

## Verification
Two pairs of events can fall in the same cycle. A trigger can arrive together with a push and a pop. A push and a pop can both arrive on a full buffer. The bench raises the trigger, push and pop strobes in one capture-mode cycle. It expects the pushed triplet to be among the newest entries kept and the pop to be dropped. It also issues a push and a pop together on a full stop-when-full buffer and expects the count to stay at 32 with no overrun. A reference model built on a queue checks the count, the flags and the head triplet every cycle.

// File: rtl/triplet_fifo_pkg.sv
package triplet_fifo_pkg;
    typedef enum logic [1:0] {
        MODE_PASS = 2'b00,
        MODE_HALT = 2'b01,
        MODE_ROLL = 2'b10,
        MODE_SNAP = 2'b11
    } fmode_e;

    localparam int NAXES = 3;
endpackage

// File: rtl/triplet_fifo_store.sv
module triplet_fifo_store #(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int ENTRIES = 1 << AW;

    logic [DW-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/triplet_fifo_ctrl.sv
module triplet_fifo_ctrl
    import triplet_fifo_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic [AW-1:0] level_i,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          trig_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [AW-1:0] raddr_o,
    output logic [AW:0]   count_o,
    output logic          wm_o,
    output logic          ovr_o,
    output logic          trg_o
);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(1 << AW);
    localparam logic [CW-1:0] ONE_CNT  = CW'(1);

    typedef struct packed {
        fmode_e        mode;
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
        logic          ovr;
        logic          trg;
    } st_t;

    st_t s_d, s_q;
    logic we_d;

    always_comb begin
        logic          fire;
        logic          pop_ok;
        logic          full;
        logic          drop;
        logic          set_ovr;
        logic [CW-1:0] cap;

        s_d     = s_q;
        we_d    = 1'b0;
        fire    = 1'b0;
        pop_ok  = 1'b0;
        full    = 1'b0;
        drop    = 1'b0;
        set_ovr = 1'b0;
        cap     = FULL_CNT;

        if (mode_i != s_q.mode) begin
            s_d.mode = fmode_e'(mode_i);
            s_d.rd   = '0;
            s_d.wr   = '0;
            s_d.cnt  = '0;
            s_d.ovr  = 1'b0;
            s_d.trg  = 1'b0;
        end else begin
            cap    = (s_q.mode == MODE_PASS) ? ONE_CNT : FULL_CNT;
            fire   = (s_q.mode == MODE_SNAP) && !s_q.trg && trig_i;
            pop_ok = pop_i && (s_q.cnt != '0) && !fire;
            full   = (s_q.cnt == cap);
            drop   = (s_q.mode == MODE_PASS) || (s_q.mode == MODE_ROLL) ||
                     ((s_q.mode == MODE_SNAP) && !s_q.trg);

            if (pop_ok) begin
                s_d.rd  = s_q.rd + 1'b1;
                s_d.cnt = s_q.cnt - 1'b1;
            end

            if (push_i) begin
                if (!full || pop_ok) begin
                    we_d    = 1'b1;
                    s_d.wr  = s_q.wr + 1'b1;
                    s_d.cnt = s_d.cnt + 1'b1;
                end else if (drop) begin
                    we_d    = 1'b1;
                    s_d.wr  = s_q.wr + 1'b1;
                    s_d.rd  = s_d.rd + 1'b1;
                    set_ovr = 1'b1;
                end else begin
                    set_ovr = 1'b1;
                end
            end

            if (fire) begin
                s_d.trg = 1'b1;
                if (s_d.cnt > {1'b0, level_i}) begin
                    s_d.rd  = s_d.wr - level_i;
                    s_d.cnt = {1'b0, level_i};
                end
            end

            if (set_ovr)     s_d.ovr = 1'b1;
            else if (pop_ok) s_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{mode: MODE_PASS, rd: '0, wr: '0, cnt: '0, ovr: 1'b0, trg: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign we_o    = we_d;
    assign waddr_o = s_q.wr;
    assign raddr_o = s_q.rd;
    assign count_o = s_q.cnt;
    assign wm_o    = (s_q.cnt >= {1'b0, level_i});
    assign ovr_o   = s_q.ovr;
    assign trg_o   = s_q.trg;
endmodule

// File: rtl/triplet_fifo.sv
module triplet_fifo
    import triplet_fifo_pkg::*;
#(
    parameter int AW = 5,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic [AW-1:0] level_i,
    input  logic          push_i,
    input  logic [SW-1:0] push_x_i,
    input  logic [SW-1:0] push_y_i,
    input  logic [SW-1:0] push_z_i,
    input  logic          pop_i,
    output logic [SW-1:0] pop_x_o,
    output logic [SW-1:0] pop_y_o,
    output logic [SW-1:0] pop_z_o,
    input  logic          trig_i,
    output logic [AW:0]   count_o,
    output logic          wm_o,
    output logic          ovr_o,
    output logic          trg_o
);
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [SW-1:0] ax_in  [NAXES];
    logic [SW-1:0] ax_out [NAXES];

    assign ax_in[0] = push_x_i;
    assign ax_in[1] = push_y_i;
    assign ax_in[2] = push_z_i;

    triplet_fifo_ctrl #(.AW(AW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .level_i (level_i),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .trig_i  (trig_i),
        .we_o    (we),
        .waddr_o (waddr),
        .raddr_o (raddr),
        .count_o (count_o),
        .wm_o    (wm_o),
        .ovr_o   (ovr_o),
        .trg_o   (trg_o)
    );

    for (genvar a = 0; a < NAXES; a++) begin : g_axis
        triplet_fifo_store #(.AW(AW), .DW(SW)) u_store (
            .clk     (clk),
            .we_i    (we),
            .waddr_i (waddr),
            .wdata_i (ax_in[a]),
            .raddr_i (raddr),
            .rdata_o (ax_out[a])
        );
    end

    assign pop_x_o = ax_out[0];
    assign pop_y_o = ax_out[1];
    assign pop_z_o = ax_out[2];
endmodule

// File: rtl/triplet_fifo_chk.sv
module triplet_fifo_chk #(
    parameter int AW = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  mode_i,
    input logic        push_i,
    input logic        pop_i,
    input logic        trig_i,
    input logic [AW:0] count_o,
    input logic        ovr_o,
    input logic        trg_o
);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(1 << AW);

    // R2
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= FULL_CNT);

    // R1
    mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != $past(mode_i)) |=> (count_o == '0 && !ovr_o && !trg_o));

    // R3
    halt_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && $stable(mode_i) && count_o == FULL_CNT && push_i && !pop_i)
        |=> (count_o == FULL_CNT && ovr_o));

    // R5
    pass_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 && $stable(mode_i)) |-> (count_o <= (AW+1)'(1)));

    // R8
    trg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_o && $stable(mode_i)) |=> trg_o);

    // R11
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(mode_i) && mode_i != 2'b00 && count_o == FULL_CNT && push_i && pop_i && !trig_i)
        |=> (count_o == FULL_CNT));
endmodule

bind triplet_fifo triplet_fifo_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .trig_i  (trig_i),
    .count_o (count_o),
    .ovr_o   (ovr_o),
    .trg_o   (trg_o)
);

// File: tb/triplet_fifo_bench.sv
`timescale 1ns/1ps
module triplet_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [4:0]  level_i = 5'd4;
    logic        push_i = 1'b0;
    logic [15:0] push_x_i = '0, push_y_i = '0, push_z_i = '0;
    logic        pop_i = 1'b0;
    logic        trig_i = 1'b0;
    logic [15:0] pop_x_o, pop_y_o, pop_z_o;
    logic [5:0]  count_o;
    logic        wm_o, ovr_o, trg_o;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;
    int cur_mode = 0;
    int cur_level = 4;
    logic [15:0] seq = 16'h0100;

    logic [47:0] mq[$];
    bit m_ovr = 0;
    bit m_trg = 0;
    int m_mode = 0;

    always #2.5 clk = ~clk;

    triplet_fifo u_triplet_fifo (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .level_i(level_i),
        .push_i(push_i), .push_x_i(push_x_i), .push_y_i(push_y_i), .push_z_i(push_z_i),
        .pop_i(pop_i), .pop_x_o(pop_x_o), .pop_y_o(pop_y_o), .pop_z_o(pop_z_o),
        .trig_i(trig_i), .count_o(count_o), .wm_o(wm_o), .ovr_o(ovr_o), .trg_o(trg_o)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cyc_cnt);
            finish_run();
        end
    end

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        chk(count_o == 6'(mq.size()), tag, "count", count_o, mq.size());
        chk(wm_o == (mq.size() >= cur_level), tag, "watermark", wm_o, mq.size() >= cur_level);
        chk(ovr_o == m_ovr, tag, "overrun", ovr_o, m_ovr);
        chk(trg_o == m_trg, tag, "triggered", trg_o, m_trg);
        if (mq.size() > 0)
            chk({pop_x_o, pop_y_o, pop_z_o} == mq[0], tag, "head triplet",
                {pop_x_o, pop_y_o, pop_z_o}, mq[0]);
    endtask

    task automatic model_step(bit push, bit pop, bit trig, logic [47:0] d);
        int  cap;
        bit  fire, dp, so;
        if (cur_mode != m_mode) begin
            mq.delete();
            m_ovr = 0;
            m_trg = 0;
            m_mode = cur_mode;
            return;
        end
        fire = (cur_mode == 3) && !m_trg && trig;
        dp   = pop && (mq.size() > 0) && !fire;
        cap  = (cur_mode == 0) ? 1 : 32;
        so   = 0;
        if (dp) void'(mq.pop_front());
        if (push) begin
            if (mq.size() < cap) mq.push_back(d);
            else begin
                so = 1;
                if (cur_mode == 0 || cur_mode == 2 || (cur_mode == 3 && !m_trg)) begin
                    void'(mq.pop_front());
                    mq.push_back(d);
                end
            end
        end
        if (fire) begin
            m_trg = 1;
            while (mq.size() > cur_level) void'(mq.pop_front());
        end
        if (so) m_ovr = 1;
        else if (dp) m_ovr = 0;
    endtask

    task automatic cyc(bit push, bit pop, bit trig, string tag);
        logic [47:0] d;
        seq = seq + 16'd1;
        d = {seq, seq ^ 16'h5a5a, ~seq};
        mode_i   = 2'(cur_mode);
        level_i  = 5'(cur_level);
        push_i   = push;
        pop_i    = pop;
        trig_i   = trig;
        push_x_i = d[47:32];
        push_y_i = d[31:16];
        push_z_i = d[15:0];
        #0.5;
        compare(tag);
        @(posedge clk);
        model_step(push, pop, trig, d);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0, "R1");

        // stop-when-full mode; push in the switching cycle is ignored
        cur_mode = 1;
        cyc(1, 0, 0, "R1");
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, "R2");
        for (int i = 0; i < 2; i++) cyc(0, 1, 0, "R2");
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, "R2");
        cur_level = 10;
        for (int i = 0; i < 32; i++) cyc(1, 0, 0, "R9");
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R3");
        cyc(1, 1, 0, "R11");
        cyc(1, 0, 0, "R3");
        cyc(1, 1, 0, "R10");
        cyc(0, 1, 0, "R10");
        cur_level = 31;
        cyc(0, 0, 0, "R9");
        cur_level = 0;
        cyc(0, 0, 0, "R9");

        // rolling mode
        cur_mode = 2;
        cyc(0, 0, 0, "R1");
        for (int i = 0; i < 40; i++) cyc(1, 0, 0, "R4");
        for (int i = 0; i < 33; i++) cyc(0, 1, 0, "R4");

        // single-slot mode
        cur_mode = 0;
        cyc(1, 0, 0, "R1");
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R5");
        cyc(1, 1, 0, "R5");
        cyc(0, 1, 0, "R5");
        cyc(0, 1, 0, "R5");

        // capture mode: trigger with push and pop in the same cycle
        cur_mode = 3;
        cur_level = 5;
        cyc(0, 0, 0, "R1");
        for (int i = 0; i < 40; i++) cyc(1, 0, 0, "R6");
        cyc(1, 1, 1, "R7");
        for (int i = 0; i < 30; i++) cyc(1, 0, 0, "R8");
        cyc(1, 0, 1, "R8");
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R8");

        // leave and re-enter capture; retention level zero
        cur_mode = 1;
        cyc(0, 0, 0, "R1");
        cur_mode = 3;
        cur_level = 0;
        cyc(0, 0, 0, "R1");
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R6");
        cyc(0, 0, 1, "R7");
        cyc(0, 0, 0, "R7");

        // count below level: nothing removed
        cur_mode = 2;
        cyc(0, 0, 0, "R1");
        cur_mode = 3;
        cur_level = 8;
        cyc(0, 0, 0, "R1");
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R6");
        cyc(0, 1, 1, "R7");
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, "R7");

        finish_run();
    end
endmodule